// File: doc/BRIEF.md
# Armed Ring-Buffer Capture Controller

This block runs a two-channel sample recorder around an external pair of buffer RAMs. Software configures it through a small word-addressed register port: the decimation factor, the number of samples to keep after the event, and a trigger-source field. It then arms the recorder. While armed, the block stores one sample from each 14-bit channel per decimation period. Both channels are written at one shared address, which steps through a ring of `DEPTH` words. The ring keeps the history from before the event.

A single-cycle trigger input marks the event. The block records the ring address of the first sample after the event. It keeps storing for the programmed count of further decimated samples, then stops and raises a done flag. Software reads the current write address and the latched event address, and then unrolls the ring from them. Once an event is accepted, the trigger-source field reads back as zero, so polling software can see that the event happened. A reset bit stops the recorder at any time. Arming again while a capture runs restarts it at the current address.

Top module: `ring_capture_ctrl`

## Requirements
- R1: Writing 1 to control bit 1 (word 0) returns the recorder to idle. No buffer write happens in that cycle or afterwards, and the done flag is cleared. This bit takes priority over the arm bit when both are written together.
- R2: Writing 1 to control bit 0 (word 0) enters the pre-event phase, clears done and restarts the decimation phase. Storing continues from the current write address. This also holds when a capture is already in its pre-event or post-event phase.
- R3: Word 2 holds the decimation factor D and resets to 1. A write takes effect only for the values 1, 8, 64, 1024, 8192 and 65536; any other value leaves the register unchanged. While capturing, consecutive stores are exactly D cycles apart.
- R4: Each store writes both channels at the same address. Each word is the channel's 14-bit two's-complement input, sign-extended to 32 bits, as present at the clock edge that performs the store. `buf_we` is a one-cycle pulse that is visible after that edge.
- R5: Each store uses the current write address, then advances it by one, wrapping from DEPTH-1 to 0. After reset the address is 0.
- R6: A trigger pulse is accepted only in the pre-event phase. A pulse while idle or in the post-event phase changes no state.
- R7: On an accepted trigger, word 5 latches the address that the first post-event sample will use.
- R8: After an accepted trigger with delay N (word 3), exactly N further samples are stored, and then the recorder goes idle with done set. With N = 0 it stops at the trigger edge.
- R9: The trigger-source field (word 1, bits 3:0) reads back the last value written, and reads 0 from the cycle after an accepted trigger.
- R10: `reg_rdata` shows, one cycle after `reg_addr` is presented, the selected word:
  - word 0 is status: bit 0 pre-event, bit 1 post-event, bit 2 done;
  - words 1 to 3 are the configuration;
  - word 4 is the current write address;
  - word 5 is the latched trigger address;
  - other addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| adc_a | input | 14 | Channel A sample |
| adc_b | input | 14 | Channel B sample |
| trig_in | input | 1 | Single-cycle trigger event |
| buf_we | output | 1 | Buffer write enable, both channels |
| buf_addr | output | 14 | Shared buffer write address |
| buf_dat_a | output | 32 | Channel A buffer word |
| buf_dat_b | output | 32 | Channel B buffer word |

## Verification
A store appears on the buffer port one clock after the edge that samples the inputs, so the bench compares each written word against the input value it latched at that same edge. It compares the address against its own running count of stores. Register reads are due one edge after the address is set, so every read waits a full cycle before sampling. The latched trigger address is due at the trigger edge, so the bench records its expected value just after the falling edge that follows the pulse, once that edge's store has been counted. Completion is polled through the status word with a bounded loop, and then the count of post-event stores is compared with the delay.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_POST = 2'd2
  } cap_state_e;

  localparam int DEC_W = 17;
  localparam int REG_W = 32;
  localparam int SRC_W = 4;

  localparam logic [2:0] RA_CTRL  = 3'd0;
  localparam logic [2:0] RA_SRC   = 3'd1;
  localparam logic [2:0] RA_DEC   = 3'd2;
  localparam logic [2:0] RA_DELAY = 3'd3;
  localparam logic [2:0] RA_CUR   = 3'd4;
  localparam logic [2:0] RA_TRIG  = 3'd5;

  function automatic logic dec_legal(input logic [DEC_W-1:0] v);
    case (v)
      17'd1, 17'd8, 17'd64, 17'd1024, 17'd8192, 17'd65536: dec_legal = 1'b1;
      default: dec_legal = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/cap_cfg_regs.sv
module cap_cfg_regs
  import cap_pkg::*;
#(
  parameter int AW    = 14,
  parameter int DLY_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic              trig_hit,
  input  logic [2:0]        status,
  input  logic [AW-1:0]     wr_ptr,
  input  logic [AW-1:0]     trig_ptr,
  output logic              arm_p,
  output logic              rst_p,
  output logic [DEC_W-1:0]  dec_q,
  output logic [DLY_W-1:0]  delay_q,
  output logic [REG_W-1:0]  reg_rdata
);
  logic [SRC_W-1:0] src_q;
  logic             ctrl_wr;

  assign ctrl_wr = reg_wr && (reg_addr == RA_CTRL);
  assign arm_p   = ctrl_wr && reg_wdata[0];
  assign rst_p   = ctrl_wr && reg_wdata[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q   <= '0;
      dec_q   <= DEC_W'(1);
      delay_q <= '0;
    end else begin
      if (trig_hit)
        src_q <= '0;
      else if (reg_wr && reg_addr == RA_SRC)
        src_q <= reg_wdata[SRC_W-1:0];
      if (reg_wr && reg_addr == RA_DEC && dec_legal(reg_wdata[DEC_W-1:0]))
        dec_q <= reg_wdata[DEC_W-1:0];
      if (reg_wr && reg_addr == RA_DELAY)
        delay_q <= reg_wdata[DLY_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_addr)
        RA_CTRL:  reg_rdata <= REG_W'(status);
        RA_SRC:   reg_rdata <= REG_W'(src_q);
        RA_DEC:   reg_rdata <= REG_W'(dec_q);
        RA_DELAY: reg_rdata <= REG_W'(delay_q);
        RA_CUR:   reg_rdata <= REG_W'(wr_ptr);
        RA_TRIG:  reg_rdata <= REG_W'(trig_ptr);
        default:  reg_rdata <= '0;
      endcase
    end
  end

  AST_DEC_LEGAL: assert property (@(posedge clk) disable iff (rst) dec_legal(dec_q)); // R3
  AST_SRC_CLEAR: assert property (@(posedge clk) disable iff (rst) trig_hit |=> (src_q == '0)); // R9
endmodule

// File: rtl/cap_decim.sv
module cap_decim
  import cap_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic [DEC_W-1:0] dec_q,
  output logic             tick
);
  logic [DEC_W-1:0] cnt;

  assign tick = run && (cnt >= dec_q - DEC_W'(1));

  always_ff @(posedge clk) begin
    if (rst || restart || !run)
      cnt <= '0;
    else if (tick)
      cnt <= '0;
    else
      cnt <= cnt + DEC_W'(1);
  end
endmodule

// File: rtl/cap_fsm.sv
module cap_fsm
  import cap_pkg::*;
#(
  parameter int SMP_W = 14,
  parameter int DEPTH = 16384,
  parameter int AW    = 14,
  parameter int DLY_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm_p,
  input  logic              rst_p,
  input  logic              trig_in,
  input  logic              tick,
  input  logic [DLY_W-1:0]  delay_q,
  input  logic [SMP_W-1:0]  adc_a,
  input  logic [SMP_W-1:0]  adc_b,
  output cap_state_e        state,
  output logic              done,
  output logic              trig_hit,
  output logic [AW-1:0]     wr_ptr,
  output logic [AW-1:0]     trig_ptr,
  output logic              buf_we,
  output logic [AW-1:0]     buf_addr,
  output logic [REG_W-1:0]  buf_dat_a,
  output logic [REG_W-1:0]  buf_dat_b
);
  logic [DLY_W-1:0] del_cnt;
  logic [AW-1:0]    nxt_ptr;
  logic             store;

  assign nxt_ptr  = (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + AW'(1);
  assign store    = (state != ST_IDLE) && tick && !rst_p;
  assign trig_hit = (state == ST_PRE) && trig_in && !arm_p && !rst_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_we    <= 1'b0;
      buf_addr  <= '0;
      buf_dat_a <= '0;
      buf_dat_b <= '0;
      wr_ptr    <= '0;
    end else begin
      buf_we <= store;
      if (store) begin
        buf_addr  <= wr_ptr;
        buf_dat_a <= {{(REG_W-SMP_W){adc_a[SMP_W-1]}}, adc_a};
        buf_dat_b <= {{(REG_W-SMP_W){adc_b[SMP_W-1]}}, adc_b};
        wr_ptr    <= nxt_ptr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      done     <= 1'b0;
      trig_ptr <= '0;
      del_cnt  <= '0;
    end else if (rst_p) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else if (arm_p) begin
      state <= ST_PRE;
      done  <= 1'b0;
    end else begin
      case (state)
        ST_PRE: if (trig_in) begin
          trig_ptr <= tick ? nxt_ptr : wr_ptr;
          if (delay_q == '0) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            state   <= ST_POST;
            del_cnt <= delay_q;
          end
        end
        ST_POST: if (tick) begin
          del_cnt <= del_cnt - DLY_W'(1);
          if (del_cnt == DLY_W'(1)) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  AST_IDLE_QUIET:    assert property (@(posedge clk) disable iff (rst) (state == ST_IDLE) |=> !buf_we); // R1
  AST_POST_NONZERO:  assert property (@(posedge clk) disable iff (rst) (state == ST_POST) |-> (del_cnt != '0)); // R8
  AST_DONE_IS_IDLE:  assert property (@(posedge clk) disable iff (rst) done |-> (state == ST_IDLE)); // R8
  AST_TRIG_PTR_HOLD: assert property (@(posedge clk) disable iff (rst) (state != ST_PRE) |=> $stable(trig_ptr)); // R6
endmodule

// File: rtl/ring_capture_ctrl.sv
module ring_capture_ctrl
  import cap_pkg::*;
#(
  parameter int SMP_W = 14,
  parameter int DEPTH = 16384,
  parameter int DLY_W = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic [2:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic [SMP_W-1:0] adc_a,
  input  logic [SMP_W-1:0] adc_b,
  input  logic             trig_in,
  output logic             buf_we,
  output logic [AW-1:0]    buf_addr,
  output logic [31:0]      buf_dat_a,
  output logic [31:0]      buf_dat_b
);
  logic             arm_p, rst_p, tick, done, trig_hit;
  logic [DEC_W-1:0] dec_q;
  logic [DLY_W-1:0] delay_q;
  logic [AW-1:0]    wr_ptr, trig_ptr;
  cap_state_e       state;
  logic [2:0]       status;

  assign status = {done, state == ST_POST, state == ST_PRE};

  cap_cfg_regs #(.AW(AW), .DLY_W(DLY_W)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .trig_hit(trig_hit), .status(status),
    .wr_ptr(wr_ptr), .trig_ptr(trig_ptr), .arm_p(arm_p), .rst_p(rst_p),
    .dec_q(dec_q), .delay_q(delay_q), .reg_rdata(reg_rdata)
  );

  cap_decim u_decim (
    .clk(clk), .rst(rst), .run(state != ST_IDLE), .restart(arm_p || rst_p),
    .dec_q(dec_q), .tick(tick)
  );

  cap_fsm #(.SMP_W(SMP_W), .DEPTH(DEPTH), .AW(AW), .DLY_W(DLY_W)) u_fsm (
    .clk(clk), .rst(rst), .arm_p(arm_p), .rst_p(rst_p), .trig_in(trig_in),
    .tick(tick), .delay_q(delay_q), .adc_a(adc_a), .adc_b(adc_b),
    .state(state), .done(done), .trig_hit(trig_hit), .wr_ptr(wr_ptr),
    .trig_ptr(trig_ptr), .buf_we(buf_we), .buf_addr(buf_addr),
    .buf_dat_a(buf_dat_a), .buf_dat_b(buf_dat_b)
  );
endmodule

// File: tb/sim_ring_capture_ctrl.sv
`timescale 1ns/1ps
module sim_ring_capture_ctrl;
  localparam int DEPTH = 16384;

  logic        clk = 0, rst = 1, reg_wr = 0, trig_in = 0;
  logic [2:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [13:0] adc_a = 0, adc_b = 0, pa = 0, pb = 0;
  logic        buf_we;
  logic [13:0] buf_addr;
  logic [31:0] buf_dat_a, buf_dat_b;

  int nchk = 0, nfail = 0, cyc = 0, last_cyc = 0, nwr = 0;
  int exp_ptr = 0, exp_dec = 1, exp_trig = 0, base = 0;
  bit gap_ok = 0, fin = 0;
  logic [31:0] rv;

  always #2 clk = ~clk;

  ring_capture_ctrl u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .adc_a(adc_a), .adc_b(adc_b),
    .trig_in(trig_in), .buf_we(buf_we), .buf_addr(buf_addr),
    .buf_dat_a(buf_dat_a), .buf_dat_b(buf_dat_b)
  );

  function automatic logic [31:0] sx(input logic [13:0] v);
    return {{18{v[13]}}, v};
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    pa  <= adc_a;
    pb  <= adc_b;
    cyc <= cyc + 1;
  end

  always @(negedge clk) begin
    adc_a <= 14'($urandom);
    adc_b <= 14'($urandom);
    if (!rst && buf_we) begin
      chk(buf_addr == 14'(exp_ptr), "R5 address", buf_addr, exp_ptr);
      chk(buf_dat_a == sx(pa), "R4 chan A", buf_dat_a, sx(pa));
      chk(buf_dat_b == sx(pb), "R4 chan B", buf_dat_b, sx(pb));
      if (gap_ok) chk(cyc - last_cyc == exp_dec, "R3 spacing", cyc - last_cyc, exp_dec);
      last_cyc = cyc;
      gap_ok   = 1;
      exp_ptr  = (exp_ptr + 1) % DEPTH;
      nwr++;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    if (a == 3'd0) gap_ok = 0;
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
    #1;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic trig();
    @(negedge clk);
    trig_in = 1;
    @(negedge clk);
    trig_in = 0;
    #1;
    exp_trig = exp_ptr;
    base     = nwr;
  endtask

  task automatic wait_done(output logic [31:0] st);
    st = 0;
    for (int i = 0; i < 5000; i++) begin
      rd(3'd0, st);
      if (st[2]) break;
    end
  endtask

  task automatic capture(input int dec, input int dly, input int pre, input string tag);
    logic [31:0] st;
    wr(3'd2, 32'(dec)); exp_dec = dec;
    wr(3'd3, 32'(dly));
    wr(3'd1, 32'd9);
    wr(3'd0, 32'd1);
    idle(pre);
    trig();
    wait_done(st);
    chk(st == 32'd4, {tag, " R8 done"}, st, 4);
    chk(nwr - base == dly, {tag, " R8 post count"}, nwr - base, dly);
    rd(3'd5, rv);
    chk(rv == 32'(exp_trig), {tag, " R7 trig ptr"}, rv, exp_trig);
    rd(3'd4, rv);
    chk(rv == 32'((exp_trig + dly) % DEPTH), {tag, " R5 cur ptr"}, rv, (exp_trig + dly) % DEPTH);
    rd(3'd1, rv);
    chk(rv == 0, {tag, " R9 src cleared"}, rv, 0);
  endtask

  initial begin
    #(4 * 190000);
    if (!fin) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst = 0;
    // R10 reset state
    rd(3'd0, rv); chk(rv == 0, "R10 status reset", rv, 0);
    rd(3'd2, rv); chk(rv == 1, "R10 dec reset", rv, 1);
    rd(3'd4, rv); chk(rv == 0, "R10 cur reset", rv, 0);
    rd(3'd6, rv); chk(rv == 0, "R10 unmapped", rv, 0);
    chk(buf_we == 0, "R1 no write at reset", buf_we, 0);
    // R3 legality
    wr(3'd2, 32'd3);     rd(3'd2, rv); chk(rv == 1, "R3 illegal ignored", rv, 1);
    wr(3'd2, 32'd65536); rd(3'd2, rv); chk(rv == 65536, "R3 legal 65536", rv, 65536);
    wr(3'd2, 32'd0);     rd(3'd2, rv); chk(rv == 65536, "R3 zero ignored", rv, 65536);
    wr(3'd2, 32'd1024);  rd(3'd2, rv); chk(rv == 1024, "R3 legal 1024", rv, 1024);
    // R6 trigger while idle ignored
    wr(3'd1, 32'd5);
    trig();
    idle(5);
    rd(3'd1, rv); chk(rv == 5, "R6 idle trig src kept", rv, 5);
    chk(nwr == 0, "R6 idle no writes", nwr, 0);
    // directed captures
    capture(8, 10, 50, "dir8");
    capture(1, 0, 7, "dly0");
    base = nwr; idle(10);
    chk(nwr == base, "R8 stopped after delay0", nwr, base);
    // R6 second trigger in post phase ignored
    wr(3'd2, 32'd1); exp_dec = 1;
    wr(3'd3, 32'd30);
    wr(3'd0, 32'd1);
    idle(10);
    trig();
    idle(5);
    begin
      int t0;
      t0 = exp_trig;
      @(negedge clk); trig_in = 1; @(negedge clk); trig_in = 0;
      wait_done(rv);
      rd(3'd5, rv); chk(rv == 32'(t0), "R6 post trig ignored", rv, t0);
      chk(nwr - base == 30, "R8 count with extra trig", nwr - base, 30);
    end
    // R1 reset bit stops writing
    wr(3'd0, 32'd1);
    idle(10);
    wr(3'd0, 32'd2);
    base = nwr; idle(20);
    chk(nwr == base, "R1 reset stops writes", nwr, base);
    rd(3'd0, rv); chk(rv == 0, "R1 status idle", rv, 0);
    wr(3'd0, 32'd3);
    base = nwr; idle(10);
    chk(nwr == base, "R1 reset beats arm", nwr, base);
    // R2 re-arm during post phase
    wr(3'd3, 32'd50);
    wr(3'd0, 32'd1);
    idle(5);
    trig();
    idle(5);
    wr(3'd0, 32'd1);
    rd(3'd0, rv); chk(rv == 1, "R2 rearm back to pre", rv, 1);
    wr(3'd3, 32'd4);
    idle(6);
    trig();
    wait_done(rv);
    rd(3'd5, rv); chk(rv == 32'(exp_trig), "R2 new trig ptr", rv, exp_trig);
    chk(nwr - base == 4, "R2 post count after rearm", nwr - base, 4);
    // R2 re-arm in pre phase with dec 64
    wr(3'd2, 32'd64); exp_dec = 64;
    wr(3'd3, 32'd3);
    wr(3'd0, 32'd1);
    idle(150);
    wr(3'd0, 32'd1);
    idle(100);
    trig();
    wait_done(rv);
    chk(nwr - base == 3, "R2 rearm pre count", nwr - base, 3);
    // random captures
    for (int k = 0; k < 8; k++) begin
      int d;
      case ($urandom % 3)
        0: d = 1;
        1: d = 8;
        default: d = 64;
      endcase
      capture(d, int'($urandom % 40), int'($urandom % 80) + 3, "rand");
    end
    // R5 wrap
    wr(3'd2, 32'd1); exp_dec = 1;
    wr(3'd0, 32'd1);
    idle(DEPTH + 20);
    wr(3'd0, 32'd2);
    rd(3'd4, rv); chk(rv == 32'(exp_ptr), "R5 wrap cur ptr", rv, exp_ptr);
    chk(nwr > DEPTH, "R5 wrapped", nwr, DEPTH);
    fin = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule